// File: doc/BRIEF.md
# Daisy-Chained Bus Request and Tenure Controller

This block is the bus-mastering front end of an add-in card on a shared peripheral bus. When local logic has work queued, it pulls an active-low request line. It then waits for the grant that comes down a daisy chain, card to card, and for any other master's busy line to clear. While the card is not requesting, the grant passes straight through to the next card. While it is requesting, the grant stops here.

Once the bus is won, the card drops its request and drives an active-low busy line for the whole tenure. During the tenure it hands the local engine a run of transfers, one at a time, through a start/done handshake. Busy is released when the local queue runs dry, when a fixed number of transfers is done, or when a time budget derived from the clock frequency runs out, whichever comes first. After a release the card stays quiet for at least one clock before it can request again.

Top module: `bus_hold_master`

## Requirements
- R1: While reset is held and right after it, bus_req_n, busy_out_n and ack_out_n-blocking are inactive: bus_req_n=1, busy_out_n=1, xfer_start=0, and ack_out_n equals ack_in_n.
- R2: When the card is neither requesting nor holding the bus, ack_out_n equals ack_in_n in the same cycle.
- R3: When the card is idle and xfer_req=1 is sampled at a clock edge, bus_req_n is 0 from that edge on. ack_out_n stays 1 while bus_req_n=0 or busy_out_n=0, whatever the value of ack_in_n.
- R4: While requesting, the card takes the bus at the first edge that samples ack_in_n=0 together with busy_in_n=1. From that edge on, busy_out_n=0 and bus_req_n=1. It never takes the bus while busy_in_n=0.
- R5: During a tenure, xfer_start is a one-cycle pulse. After a pulse, the next one comes no earlier than the cycle after xfer_done=1. xfer_start is raised only when xfer_req=1, and at most MAX_XFERS times per tenure. It is raised on the first tenure cycle and again in the cycle after each xfer_done.
- R6: If xfer_req=0, or MAX_XFERS transfers are done, and no transfer is outstanding, busy_out_n returns to 1 at the next edge.
- R7: busy_out_n stays 0 for at most T = CLK_MHZ*TENURE_NS/1000 cycles. No xfer_start is issued in the last tenure cycle.
- R8: After busy_out_n returns to 1, bus_req_n stays 1 for at least the following cycle, even if xfer_req=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_req | input | 1 | Local queue holds at least one transfer |
| xfer_done | input | 1 | Local engine finished the outstanding transfer |
| xfer_start | output | 1 | One-cycle pulse: perform one transfer now |
| bus_req_n | output | 1 | Active-low bus request to the arbiter |
| ack_in_n | input | 1 | Active-low grant from the upstream card or arbiter |
| ack_out_n | output | 1 | Active-low grant passed to the downstream card |
| busy_in_n | input | 1 | Active-low busy sensed from other masters |
| busy_out_n | output | 1 | Active-low busy driven by this card during its tenure |

## Verification
The hardest case to reach is a tenure cut off by the time budget while a transfer is still outstanding. It needs a slow engine and enough queued work, and the transfer limit must not close the tenure first. The bench builds the block with a budget of only 16 cycles. It sweeps the queue depth, the done latency, the grant delay and the competing busy length, so that some combinations end on the empty queue, some on the transfer cap and some on the timer. For each combination it predicts the exact grant cycle, each start cycle and the tenure length.

// File: rtl/bhm_pkg.sv
package bhm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_HOLD, ST_GAP} arb_state_t;

  // clock cycles available in one tenure
  function automatic int tenure_cycles(input int mhz, input int ns);
    return (mhz * ns) / 1000;
  endfunction
endpackage

// File: rtl/tenure_timer.sv
module tenure_timer #(
  parameter int TCYC = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tmo
);
  localparam int TW = (TCYC < 2) ? 1 : $clog2(TCYC);
  localparam logic [TW-1:0] LAST = TW'(TCYC - 1);

  logic [TW-1:0] cnt;

  assign tmo = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!tmo)      cnt <= cnt + 1'b1;
  end

  a_r7_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !run || (cnt == '0));
endmodule

// File: rtl/xfer_tracker.sv
module xfer_tracker #(
  parameter int MAXX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic xfer_req,
  input  logic xfer_done,
  input  logic tmo,
  output logic xfer_start,
  output logic drained
);
  localparam int CW = $clog2(MAXX + 1);
  localparam logic [CW-1:0] CAP = CW'(MAXX);

  logic          in_flight;
  logic [CW-1:0] cnt;
  logic          cap_hit;

  assign cap_hit    = (cnt == CAP);
  assign xfer_start = hold && !in_flight && xfer_req && !cap_hit && !tmo;
  assign drained    = hold && !in_flight && (cap_hit || !xfer_req);

  always_ff @(posedge clk) begin
    if (!rst_n || !hold) begin
      in_flight <= 1'b0;
      cnt       <= '0;
    end else if (xfer_start) begin
      in_flight <= 1'b1;
      cnt       <= cnt + 1'b1;
    end else if (in_flight && xfer_done) begin
      in_flight <= 1'b0;
    end
  end

  a_r5_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
endmodule

// File: rtl/ack_chain.sv
module ack_chain (
  input  logic ack_in_n,
  input  logic block,
  output logic ack_out_n
);
  assign ack_out_n = ack_in_n | block;
endmodule

// File: rtl/bus_hold_master.sv
module bus_hold_master
  import bhm_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int TENURE_NS = 8000,
  parameter int MAX_XFERS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_req,
  input  logic xfer_done,
  output logic xfer_start,
  output logic bus_req_n,
  input  logic ack_in_n,
  output logic ack_out_n,
  input  logic busy_in_n,
  output logic busy_out_n
);
  localparam int TCYC = tenure_cycles(CLK_MHZ, TENURE_NS);

  arb_state_t st, st_nx;
  logic ev_grant, ev_release, tmo, drained, holding, blocking;

  assign holding    = (st == ST_HOLD);
  assign blocking   = (st == ST_REQ) || holding;
  assign ev_grant   = (st == ST_REQ) && !ack_in_n && busy_in_n;
  assign ev_release = holding && (tmo || drained);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (xfer_req)   st_nx = ST_REQ;
      ST_REQ:  if (ev_grant)   st_nx = ST_HOLD;
      ST_HOLD: if (ev_release) st_nx = ST_GAP;
      default:                 st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign bus_req_n  = (st != ST_REQ);
  assign busy_out_n = !holding;

  tenure_timer #(.TCYC(TCYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(holding), .tmo(tmo)
  );

  xfer_tracker #(.MAXX(MAX_XFERS)) u_trk (
    .clk(clk), .rst_n(rst_n), .hold(holding), .xfer_req(xfer_req),
    .xfer_done(xfer_done), .tmo(tmo), .xfer_start(xfer_start), .drained(drained)
  );

  ack_chain u_ack (.ack_in_n(ack_in_n), .block(blocking), .ack_out_n(ack_out_n));

  a_r3_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req_n || !busy_out_n) |-> ack_out_n);
  a_r4_take_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_out_n) |-> $past(!ack_in_n && busy_in_n && !bus_req_n));
  a_r4_req_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_out_n |-> bus_req_n);
  a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_out_n) |=> bus_req_n);
endmodule

// File: tb/sim_bus_hold_master.sv
module sim_bus_hold_master;
  localparam int T = 16;
  localparam int MAXX = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, xfer_req, xfer_done, ack_in_n, busy_in_n;
  logic xfer_start, bus_req_n, ack_out_n, busy_out_n;

  bus_hold_master #(.CLK_MHZ(2), .TENURE_NS(8000), .MAX_XFERS(MAXX)) u0 (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_done(xfer_done),
    .xfer_start(xfer_start), .bus_req_n(bus_req_n), .ack_in_n(ack_in_n),
    .ack_out_n(ack_out_n), .busy_in_n(busy_in_n), .busy_out_n(busy_out_n)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic run_one(input int nq, input int lat, input int ga, input int gb);
    int n, e, wait_c, rem, pend, starts, exp_st;
    n = imin(nq, MAXX);
    e = imin(n * (lat + 1) + 1, T);
    wait_c = (ga > gb) ? ga : gb;
    // idle cycle: raise the queue
    xfer_req = 1; xfer_done = 0; ack_in_n = 1; busy_in_n = 1; #1;
    chk(bus_req_n == 1, "R3 idle before edge", bus_req_n, 1);
    tick();
    for (int rel = 0; rel <= wait_c; rel++) begin
      ack_in_n = (rel >= ga) ? 1'b0 : 1'b1;
      busy_in_n = (rel < gb) ? 1'b0 : 1'b1;
      #1;
      chk(bus_req_n == 0, "R3 request", bus_req_n, 0);
      chk(ack_out_n == 1, "R3 ack held while requesting", ack_out_n, 1);
      chk(busy_out_n == 1, "R4 not yet taken", busy_out_n, 1);
      tick();
    end
    rem = nq; pend = -1; starts = 0;
    for (int c = 0; c <= e; c++) begin
      busy_in_n = 1;
      if (c < e) begin
        xfer_req = (rem > 0); xfer_done = (c == pend); ack_in_n = 0;
        #1;
        chk(busy_out_n == 0, "R4 busy held in tenure", busy_out_n, 0);
        chk(bus_req_n == 1, "R4 request dropped", bus_req_n, 1);
        chk(ack_out_n == 1, "R3 ack held while busy", ack_out_n, 1);
        exp_st = ((c % (lat + 1)) == 0) && (c / (lat + 1) < n) && (c <= T - 2);
        chk(xfer_start == exp_st[0], "R5 start cycle", xfer_start, exp_st);
        if (xfer_start) begin starts++; pend = c + lat; end
        if (xfer_done) rem--;
      end else begin
        xfer_req = 1; xfer_done = 0; ack_in_n = 1;
        #1;
        chk(busy_out_n == 1, (e == T) ? "R7 timeout release" : "R6 drain release", busy_out_n, 1);
        chk(bus_req_n == 1, "R8 no request right after release", bus_req_n, 1);
        exp_st = 0;
        for (int k = 0; k < n; k++) if (k * (lat + 1) <= T - 2) exp_st++;
        chk(starts == exp_st, "R5 starts per tenure", starts, exp_st);
      end
      tick();
    end
    xfer_req = 0;
    for (int i = 0; i < 2; i++) begin
      ack_in_n = i[0]; #1;
      chk(ack_out_n == ack_in_n, "R2 pass-through when idle", ack_out_n, ack_in_n);
      chk(bus_req_n == 1, "R8 quiet after release", bus_req_n, 1);
      tick();
    end
  endtask

  initial begin
    rst_n = 0; xfer_req = 1; xfer_done = 0; ack_in_n = 1; busy_in_n = 1;
    tick(); tick();
    for (int v = 0; v < 2; v++) begin
      ack_in_n = v[0]; #1;
      chk(bus_req_n == 1, "R1 reset request", bus_req_n, 1);
      chk(busy_out_n == 1, "R1 reset busy", busy_out_n, 1);
      chk(xfer_start == 0, "R1 reset start", xfer_start, 0);
      chk(ack_out_n == ack_in_n, "R1 reset pass-through", ack_out_n, ack_in_n);
      tick();
    end
    xfer_req = 0; rst_n = 1; tick();
    for (int nq = 1; nq <= 6; nq++)
      for (int lat = 1; lat <= 3; lat++)
        for (int ga = 0; ga <= 2; ga++)
          for (int gb = 0; gb <= 2; gb++)
            run_one(nq, lat, ga, gb);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule